// File: doc/BRIEF.md
# Two-Wire Controller FIFO Status Flags

This block sits between the processor side and the bus engine of a two-wire serial controller. It holds a transmit FIFO of command entries and a receive FIFO of data bytes, and it raises four raw interrupt flags: transmit overflow, receive level at threshold, receive overflow and receive underflow. It also reports both FIFO levels and asks the bus engine to stall when the receive FIFO is full and stalling is selected.

The processor pushes commands on a valid/ready stream (`cmd_*`) and pops received bytes on a second valid/ready stream (`rx_*`). The bus engine drains commands from `tx_out_*` and delivers bytes with a one-cycle strobe `rx_in_valid`. That strobe carries no ready and cannot be held off, except through `bus_stall`. On both processor streams, `ready` never depends on `valid`. A source that asserts `valid` while the sink's readiness is low is not queued. A command offered while the transmit FIFO is full is dropped and counted as an overflow. A pop requested while no byte is valid is counted as an underflow.

An effective enable follows `enable` up at once. It goes down only when `enable` is low and `bus_idle` is high. The receive FIFO follows `enable` directly. The transmit FIFO and the three sticky flags follow the effective enable.

Top module: `twi_fifo_flags`

## Requirements
- R1: After reset all four flags are 0, both levels are 0, `cmd_ready`, `tx_out_valid`, `rx_valid` and `bus_stall` are 0.
- R2: `cmd_ready` is 1 exactly when the effective enable is 1 and the transmit level is below DEPTH. Accepted commands leave on `tx_out_data` in arrival order, and `tx_level` counts them.
- R3: A `cmd_valid` while the transmit FIFO holds DEPTH entries sets `flag_tx_over` at the next edge. That command is dropped, and the stored entries and level are unchanged.
- R4: `flag_rx_full` is registered. After each edge it equals 1 when `enable` was 1 and the receive level produced at that edge is at or above `rx_thresh`. It falls as soon as the level drops below `rx_thresh`.
- R5: With `hold_full` 0, a `rx_in_valid` strobe while the receive FIFO is full sets `flag_rx_over`. That byte is dropped, and the stored bytes keep their order.
- R6: `bus_stall` equals `hold_full` and `enable` and a full receive FIFO. While `hold_full` is 1, `flag_rx_over` never sets.
- R7: `rx_ready` while `rx_valid` is 0 sets `flag_rx_under` at the next edge.
- R8: When `enable` is 0 at an edge, the receive FIFO is emptied at that edge. `rx_level` and `flag_rx_full` read 0 afterwards, whatever bus activity continues.
- R9: While `enable` is 0 and `bus_idle` is 0, the three sticky flags and the transmit FIFO keep their state. At the edge where `enable` is 0 and `bus_idle` is 1, the effective enable falls. The sticky flags then read 0, the transmit FIFO is emptied and `cmd_ready` reads 0.
- R10: Each sticky flag clears on its own one-cycle clear input (`clr_tx_over`, `clr_rx_over`, `clr_rx_under`). A set condition in the same cycle wins over the clear.
- R11: One edge after `enable` rises, the effective enable is 1 and `cmd_ready` reads 1 while the transmit FIFO is not full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable bit |
| hold_full | input | 1 | 1: stall the bus on a full receive FIFO instead of dropping bytes |
| bus_idle | input | 1 | Bus state machines are idle |
| rx_thresh | input | CW (5) | Receive threshold level |
| cmd_valid | input | 1 | Processor command push valid |
| cmd_ready | output | 1 | Transmit FIFO can accept a command |
| cmd_data | input | DW+1 (9) | Command entry: data byte plus read/write bit |
| tx_out_valid | output | 1 | Command available to the bus engine |
| tx_out_ready | input | 1 | Bus engine takes the head command |
| tx_out_data | output | DW+1 (9) | Head command entry |
| rx_in_valid | input | 1 | Byte received from the bus (one-cycle strobe) |
| rx_in_data | input | DW (8) | Received byte |
| rx_valid | output | 1 | Receive FIFO holds a byte |
| rx_ready | input | 1 | Processor pops the head byte |
| rx_data | output | DW (8) | Head received byte |
| clr_tx_over | input | 1 | Clear transmit overflow flag |
| clr_rx_over | input | 1 | Clear receive overflow flag |
| clr_rx_under | input | 1 | Clear receive underflow flag |
| flag_tx_over | output | 1 | Transmit overflow flag |
| flag_rx_full | output | 1 | Receive level at or above threshold |
| flag_rx_over | output | 1 | Receive overflow flag |
| flag_rx_under | output | 1 | Receive underflow flag |
| tx_level | output | CW (5) | Transmit FIFO level |
| rx_level | output | CW (5) | Receive FIFO level |
| bus_stall | output | 1 | Request to the bus engine to hold the bus |

## Verification
The hardest state to reach is the disable window. In it, `enable` is already low but the bus is still busy. The receive side must be flushed at once, while the sticky flags and the transmit queue must survive until idle. The stimulus first builds up receive bytes, a pending transmit entry and a set underflow flag. It then drops `enable` with `bus_idle` held low and checks each of those separately. Only after that does it raise `bus_idle` and check them again. The overflow cases need each FIFO driven to exactly DEPTH entries, one extra write offered, and the queue drained with its order checked, so that the dropped entry is proven absent.

// File: rtl/twi_fifo_pkg.sv
package twi_fifo_pkg;
  // indices of the sticky flags in the flag vector
  localparam int FI_TXO = 0;
  localparam int FI_RXO = 1;
  localparam int FI_RXU = 2;
  localparam int NSTICKY = 3;
endpackage

// File: rtl/twi_sfifo.sv
module twi_sfifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= bump(wr_ptr);
        if (pop)  rd_ptr <= bump(rd_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/twi_sticky.sv
module twi_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (kill) q <= 1'b0;
    else if (set)  q <= 1'b1;
    else if (clr)  q <= 1'b0;
  end
endmodule

// File: rtl/twi_fifo_flags.sv
module twi_fifo_flags
  import twi_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          hold_full,
  input  logic          bus_idle,
  input  logic [CW-1:0] rx_thresh,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW:0]   cmd_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW:0]   tx_out_data,
  input  logic          rx_in_valid,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          clr_tx_over,
  input  logic          clr_rx_over,
  input  logic          clr_rx_under,
  output logic          flag_tx_over,
  output logic          flag_rx_full,
  output logic          flag_rx_over,
  output logic          flag_rx_under,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level,
  output logic          bus_stall
);
  // effective enable: rises with enable, falls only once the bus is idle
  logic en_q, en_nxt;
  assign en_nxt = enable | (en_q & ~bus_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_nxt;
  end

  // transmit FIFO
  logic          tx_full, tx_empty, tx_push, tx_pop;
  logic [CW-1:0] tx_cnt_nxt;

  assign cmd_ready    = en_q & ~tx_full;
  assign tx_push      = cmd_valid & cmd_ready;
  assign tx_out_valid = ~tx_empty;
  assign tx_pop       = tx_out_valid & tx_out_ready;

  twi_sfifo #(.W(DW + 1), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(~en_nxt),
    .push(tx_push), .din(cmd_data), .pop(tx_pop),
    .dout(tx_out_data), .count(tx_level), .count_nxt(tx_cnt_nxt),
    .full(tx_full), .empty(tx_empty)
  );

  // receive FIFO, held empty while enable is low
  logic          rx_full, rx_empty, rx_push, rx_pop;
  logic [CW-1:0] rx_cnt_nxt;

  assign rx_push   = rx_in_valid & enable & ~rx_full;
  assign rx_valid  = ~rx_empty;
  assign rx_pop    = rx_valid & rx_ready;
  assign bus_stall = hold_full & enable & rx_full;

  twi_sfifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(~enable),
    .push(rx_push), .din(rx_in_data), .pop(rx_pop),
    .dout(rx_data), .count(rx_level), .count_nxt(rx_cnt_nxt),
    .full(rx_full), .empty(rx_empty)
  );

  // threshold flag from the level this edge will produce
  logic thr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= 1'b0;
    else        thr_q <= enable & (rx_cnt_nxt >= rx_thresh);
  end
  assign flag_rx_full = thr_q;

  // sticky flags
  logic [NSTICKY-1:0] f_set, f_clr, f_q;

  always_comb begin
    f_set         = '0;
    f_clr         = '0;
    f_set[FI_TXO] = cmd_valid & en_q & tx_full;
    f_set[FI_RXO] = rx_in_valid & enable & rx_full & ~hold_full;
    f_set[FI_RXU] = rx_ready & rx_empty;
    f_clr[FI_TXO] = clr_tx_over;
    f_clr[FI_RXO] = clr_rx_over;
    f_clr[FI_RXU] = clr_rx_under;
  end

  for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
    twi_sticky u_flag (
      .clk(clk), .rst_n(rst_n), .kill(~en_nxt),
      .set(f_set[i]), .clr(f_clr[i]), .q(f_q[i])
    );
  end

  assign flag_tx_over  = f_q[FI_TXO];
  assign flag_rx_over  = f_q[FI_RXO];
  assign flag_rx_under = f_q[FI_RXU];
endmodule

// File: rtl/twi_fifo_flags_chk.sv
module twi_fifo_flags_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          hold_full,
  input logic          bus_idle,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rx_in_valid,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          clr_tx_over,
  input logic          flag_tx_over,
  input logic          flag_rx_full,
  input logic          flag_rx_over,
  input logic          flag_rx_under,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          bus_stall
);
  // R2
  ready_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (tx_level < CW'(DEPTH)));

  // R3
  tx_over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && enable && tx_level == CW'(DEPTH)) |=> (flag_tx_over && tx_level == CW'(DEPTH)));

  // R5
  rx_over_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && enable && !hold_full && rx_level == CW'(DEPTH)) |=> flag_rx_over);

  // R6
  stall_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> (hold_full && enable && rx_level == CW'(DEPTH)));

  // R6
  hold_no_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !flag_rx_over) |=> !flag_rx_over);

  // R7
  under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid && enable) |=> flag_rx_under);

  // R8
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (rx_level == '0 && !flag_rx_full));

  // R9
  keep_until_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !bus_idle && flag_tx_over && !clr_tx_over) |=> flag_tx_over);
endmodule

bind twi_fifo_flags twi_fifo_flags_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hold_full(hold_full),
  .bus_idle(bus_idle), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rx_in_valid(rx_in_valid), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .clr_tx_over(clr_tx_over), .flag_tx_over(flag_tx_over),
  .flag_rx_full(flag_rx_full), .flag_rx_over(flag_rx_over),
  .flag_rx_under(flag_rx_under), .tx_level(tx_level), .rx_level(rx_level),
  .bus_stall(bus_stall)
);

// File: tb/tb_twi_fifo_flags.sv
`timescale 1ns/1ps
module tb_twi_fifo_flags;
  localparam int DEPTH = 16;
  localparam int DW = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 0, hold_full = 0, bus_idle = 0;
  logic [CW-1:0] rx_thresh = '0;
  logic cmd_valid = 0, tx_out_ready = 0, rx_in_valid = 0, rx_ready = 0;
  logic [DW:0] cmd_data = '0;
  logic [DW-1:0] rx_in_data = '0;
  logic clr_tx_over = 0, clr_rx_over = 0, clr_rx_under = 0;
  logic cmd_ready, tx_out_valid, rx_valid, bus_stall;
  logic [DW:0] tx_out_data;
  logic [DW-1:0] rx_data;
  logic flag_tx_over, flag_rx_full, flag_rx_over, flag_rx_under;
  logic [CW-1:0] tx_level, rx_level;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  twi_fifo_flags #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold_full(hold_full),
    .bus_idle(bus_idle), .rx_thresh(rx_thresh), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .clr_tx_over(clr_tx_over),
    .clr_rx_over(clr_rx_over), .clr_rx_under(clr_rx_under),
    .flag_tx_over(flag_tx_over), .flag_rx_full(flag_rx_full),
    .flag_rx_over(flag_rx_over), .flag_rx_under(flag_rx_under),
    .tx_level(tx_level), .rx_level(rx_level), .bus_stall(bus_stall)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_cmd(input int v);
    cmd_valid = 1; cmd_data = (DW+1)'(v); step(); cmd_valid = 0;
  endtask

  task automatic push_rx(input int v);
    rx_in_valid = 1; rx_in_data = DW'(v); step(); rx_in_valid = 0;
  endtask

  task automatic pop_rx();
    rx_ready = 1; step(); rx_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1", "flags", {flag_tx_over, flag_rx_full, flag_rx_over, flag_rx_under}, 0);
    chk("R1", "levels", {tx_level, rx_level}, 0);
    chk("R1", "ready/valid/stall", {cmd_ready, tx_out_valid, rx_valid, bus_stall}, 0);
  endtask

  task automatic t_enable();
    enable = 1; step();
    chk("R11", "cmd_ready after enable", cmd_ready, 1);
  endtask

  task automatic t_tx_stream();
    push_cmd(9'h1A5); push_cmd(9'h042); push_cmd(9'h0FF);
    chk("R2", "tx_level", tx_level, 3);
    for (int i = 0; i < 3; i++) begin
      int exp = (i == 0) ? 9'h1A5 : (i == 1) ? 9'h042 : 9'h0FF;
      chk("R2", "tx order", tx_out_data, exp);
      tx_out_ready = 1; step(); tx_out_ready = 0;
    end
    chk("R2", "tx drained", {tx_out_valid, tx_level}, 0);
  endtask

  task automatic t_tx_over();
    for (int i = 0; i < DEPTH; i++) push_cmd(i + 32);
    chk("R2", "cmd_ready when full", cmd_ready, 0);
    chk("R3", "no flag before extra write", flag_tx_over, 0);
    push_cmd(9'h1EE);
    chk("R3", "flag_tx_over", flag_tx_over, 1);
    chk("R3", "level unchanged", tx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3", "stored entry kept", tx_out_data, i + 32);
      tx_out_ready = 1; step(); tx_out_ready = 0;
    end
    clr_tx_over = 1; step(); clr_tx_over = 0;
    chk("R10", "clr_tx_over", flag_tx_over, 0);
  endtask

  task automatic t_rx_thresh();
    rx_thresh = 3;
    push_rx(1); push_rx(2);
    chk("R4", "below threshold", flag_rx_full, 0);
    push_rx(3);
    chk("R4", "at threshold", flag_rx_full, 1);
    pop_rx();
    chk("R4", "dropped below", flag_rx_full, 0);
    pop_rx(); pop_rx();
    chk("R4", "rx empty", rx_level, 0);
  endtask

  task automatic t_rx_over();
    for (int i = 0; i < DEPTH; i++) push_rx(i + 16);
    chk("R5", "no flag at full", flag_rx_over, 0);
    push_rx(8'hEE);
    chk("R5", "flag_rx_over", flag_rx_over, 1);
    chk("R5", "level", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5", "byte order", rx_data, i + 16);
      pop_rx();
    end
    clr_rx_over = 1; step(); clr_rx_over = 0;
    chk("R10", "clr_rx_over", flag_rx_over, 0);
  endtask

  task automatic t_hold();
    hold_full = 1;
    for (int i = 0; i < DEPTH; i++) push_rx(i);
    chk("R6", "bus_stall", bus_stall, 1);
    push_rx(8'h77);
    chk("R6", "no rx overflow under hold", flag_rx_over, 0);
    chk("R6", "level", rx_level, DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_rx();
    chk("R6", "stall released", bus_stall, 0);
    hold_full = 0;
  endtask

  task automatic t_under();
    rx_ready = 1; clr_rx_under = 1; step(); rx_ready = 0; clr_rx_under = 0;
    chk("R7", "flag_rx_under (set beats clear, R10)", flag_rx_under, 1);
    clr_rx_under = 1; step(); clr_rx_under = 0;
    chk("R10", "clr_rx_under", flag_rx_under, 0);
    pop_rx();
    chk("R7", "flag_rx_under again", flag_rx_under, 1);
  endtask

  task automatic t_disable();
    rx_thresh = 1;
    push_rx(5); push_rx(6); push_cmd(9'h033);
    chk("R4", "flag before disable", flag_rx_full, 1);
    enable = 0; bus_idle = 0;
    rx_in_valid = 1; rx_in_data = 8'h99; step(); rx_in_valid = 0;
    chk("R8", "rx flushed", rx_level, 0);
    chk("R8", "flag_rx_full dropped", flag_rx_full, 0);
    chk("R9", "underflow kept", flag_rx_under, 1);
    chk("R9", "tx kept", tx_level, 1);
    step();
    chk("R9", "still kept", {flag_rx_under, cmd_ready}, 3);
    bus_idle = 1; step();
    chk("R9", "flags cleared at idle", {flag_tx_over, flag_rx_over, flag_rx_under}, 0);
    chk("R9", "tx flushed, not ready", {tx_level, cmd_ready}, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_enable();
    t_tx_stream();
    t_tx_over();
    t_rx_thresh();
    t_rx_over();
    t_hold();
    t_under();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule